// File: doc/BRIEF.md
# Multi-class register rename map

This block holds the architectural-to-physical register mapping of an out-of-order core for three register classes: integer, floating point and condition code. Each class has its own map table, indexed by a class-relative index. Every port takes one flat unified architectural index. The block works out the class from the range the index falls in, then uses the index relative to the start of that range. A fourth range holds misc registers. These have no table: each maps to a fixed index placed above the whole physical register space.

A rename request takes the head of the selected class's free list and makes it the new mapping. The response carries both the new and the previous physical register, so commit logic can free the old one later. Two kinds of request allocate nothing: a rename of the class's read-only zero register, and a rename of a misc register. Lookup ports read the current mapping. A write-entry port overwrites one entry and is used to restore mappings after a squash. Two status outputs report the smaller of the integer and floating-point free counts, and whether a bundle of per-class register demands can be met.

The rename request is a valid/ready stream. `req_ready` depends only on the requested index and the free counts, never on `req_valid`. A request transfers in a cycle where both are high. The response is not a stream: `rsp_valid`, `rsp_new` and `rsp_old` appear combinationally in the accept cycle and must be taken then, because there is no response back-pressure. Each free list is a FIFO seen through three signals: its head entry, its occupancy count, and a one-cycle pop strobe from this block.

Top module: `reg_rename_map`

## Requirements
- R1: Unified index decode with the default sizes: 0..15 is integer, 16..31 is floating point, 32..35 is condition code and 36..43 is misc. In each case the relative index is the unified index minus the start of its range. After reset, integer entry r maps to physical r, floating-point entry r maps to 32+r, and condition-code entry r maps to 64+r.
- R2: An accepted rename of an ordinary integer, floating-point or condition-code register does four things. It returns `rsp_new` equal to that class's free-list head. It returns `rsp_old` equal to the current mapping. It raises `rsp_valid` and exactly that class's pop strobe in the accept cycle. From the next cycle, the lookup of that register returns `rsp_new`.
- R3: A lookup in the same cycle as a rename of the same register returns the mapping from before the rename.
- R4: The zero register (by default integer relative index 0; the floating-point and condition-code zero indices default to values that never match) is always ready. A rename of it gives `rsp_valid` with `rsp_new` equal to `rsp_old`, both equal to its current mapping. It pops no free list and leaves the map unchanged.
- R5: A misc register with relative index m has physical index 72+m. This holds for lookups, and for renames, which are always ready and return 72+m as both `rsp_new` and `rsp_old` with no pop.
- R6: When the selected class's free count is zero, `req_ready` is low. No pop occurs, no response is given and the mapping does not change.
- R7: An active `we_valid` overwrites the addressed integer, floating-point or condition-code entry with `we_phys`, visible from the next cycle. A write-entry aimed at a misc index has no effect.
- R8: When a rename and a write-entry hit the same entry in one cycle, the entry ends up holding `we_phys`. The rename still returns the free-list head and the old mapping, and it still pops.
- R9: `can_rename` is high exactly when `need_int`, `need_fp` and `need_cc` are each less than or equal to the free count of their own class.
- R10: `free_min` equals the smaller of the integer and floating-point free counts. The condition-code count plays no part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Rename request valid |
| req_ready | output | 1 | Rename request can be accepted |
| req_arch | input | AW (6) | Unified architectural index to rename |
| rsp_valid | output | 1 | Rename accepted this cycle |
| rsp_new | output | PW (7) | New physical register |
| rsp_old | output | PW (7) | Previous physical register |
| lk_arch | input | NLK*AW (12) | Lookup indices, port k in bits k*AW upward |
| lk_phys | output | NLK*PW (14) | Lookup results, port k in bits k*PW upward |
| we_valid | input | 1 | Write-entry strobe |
| we_arch | input | AW (6) | Unified index to overwrite |
| we_phys | input | PW (7) | Physical register to store |
| fl_int_head | input | PW (7) | Integer free-list head |
| fl_int_count | input | CW (7) | Integer free-list occupancy |
| fl_int_pop | output | 1 | Integer free-list pop |
| fl_fp_head | input | PW (7) | Floating-point free-list head |
| fl_fp_count | input | CW (7) | Floating-point free-list occupancy |
| fl_fp_pop | output | 1 | Floating-point free-list pop |
| fl_cc_head | input | PW (7) | Condition-code free-list head |
| fl_cc_count | input | CW (7) | Condition-code free-list occupancy |
| fl_cc_pop | output | 1 | Condition-code free-list pop |
| need_int | input | CW (7) | Integer registers demanded |
| need_fp | input | CW (7) | Floating-point registers demanded |
| need_cc | input | CW (7) | Condition-code registers demanded |
| free_min | output | CW (7) | Minimum of integer and floating-point free counts |
| can_rename | output | 1 | Demands can all be met |

## Verification
Two functions can land on the same map entry in one cycle, and the bench provokes both cases on purpose. The first is a rename with a lookup of that same register. On every rename cycle, lookup port 0 is read and compared against the model's mapping from before the rename. The second is a rename with a write-entry to the same index, and a separate case aims the write-entry at a different index. In both, the scoreboard expects the free-list head and the old mapping in the response. A following lookup must then show the written value where the write-entry won, and the new register where it did not.

// File: rtl/rmap_pkg.sv
`timescale 1ns/1ps
package rmap_pkg;
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_FP   = 2'd1,
    CLS_CC   = 2'd2,
    CLS_MISC = 2'd3
  } reg_cls_e;
endpackage

// File: rtl/rmap_decode.sv
`timescale 1ns/1ps
module rmap_decode
  import rmap_pkg::*;
#(
  parameter int AW = 6,
  parameter int NI = 16,
  parameter int NF = 16,
  parameter int NC = 4
) (
  input  logic [AW-1:0] uidx,
  output reg_cls_e      cls,
  output logic [AW-1:0] rel
);
  localparam int FP_BASE   = NI;
  localparam int CC_BASE   = NI + NF;
  localparam int MISC_BASE = NI + NF + NC;

  always_comb begin
    if (int'(uidx) < FP_BASE) begin
      cls = CLS_INT;
      rel = uidx;
    end else if (int'(uidx) < CC_BASE) begin
      cls = CLS_FP;
      rel = uidx - AW'(FP_BASE);
    end else if (int'(uidx) < MISC_BASE) begin
      cls = CLS_CC;
      rel = uidx - AW'(CC_BASE);
    end else begin
      cls = CLS_MISC;
      rel = uidx - AW'(MISC_BASE);
    end
  end
endmodule

// File: rtl/rmap_class_table.sv
`timescale 1ns/1ps
module rmap_class_table #(
  parameter int NARCH = 16,
  parameter int PBASE = 0,
  parameter int AW    = 6,
  parameter int PW    = 7,
  parameter int NRD   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NRD*AW-1:0] rd_idx,
  output logic [NRD*PW-1:0] rd_phys,
  input  logic              ren_en,
  input  logic [AW-1:0]     ren_idx,
  input  logic [PW-1:0]     ren_phys,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [PW-1:0]     wr_phys
);
  logic [PW-1:0] map_w [NARCH];

  for (genvar e = 0; e < NARCH; e++) begin : g_ent
    logic [PW-1:0] ent_q;
    logic          hit_wr;
    logic          hit_ren;
    assign hit_wr  = wr_en  && (wr_idx  == AW'(e));
    assign hit_ren = ren_en && (ren_idx == AW'(e));
    // squash recovery write outranks a rename of the same entry
    always_ff @(posedge clk) begin
      if (!rst_n)       ent_q <= PW'(PBASE + e);
      else if (hit_wr)  ent_q <= wr_phys;
      else if (hit_ren) ent_q <= ren_phys;
    end
    assign map_w[e] = ent_q;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0] idx;
    logic [PW-1:0] val;
    assign idx = rd_idx[r*AW +: AW];
    always_comb begin
      val = '0;
      for (int e = 0; e < NARCH; e++) begin
        if (idx == AW'(e)) val = map_w[e];
      end
    end
    assign rd_phys[r*PW +: PW] = val;
  end
endmodule

// File: rtl/rmap_status.sv
`timescale 1ns/1ps
module rmap_status #(
  parameter int CW = 7
) (
  input  logic [CW-1:0] cnt_int,
  input  logic [CW-1:0] cnt_fp,
  input  logic [CW-1:0] cnt_cc,
  input  logic [CW-1:0] need_int,
  input  logic [CW-1:0] need_fp,
  input  logic [CW-1:0] need_cc,
  output logic [CW-1:0] free_min,
  output logic          can_rename
);
  assign free_min   = (cnt_int < cnt_fp) ? cnt_int : cnt_fp;
  assign can_rename = (need_int <= cnt_int) && (need_fp <= cnt_fp) && (need_cc <= cnt_cc);
endmodule

// File: rtl/reg_rename_map.sv
`timescale 1ns/1ps
module reg_rename_map
  import rmap_pkg::*;
#(
  parameter int NI       = 16,
  parameter int NF       = 16,
  parameter int NC       = 4,
  parameter int NM       = 8,
  parameter int PI       = 32,
  parameter int PF       = 32,
  parameter int PC       = 8,
  parameter int NLK      = 2,
  parameter int CW       = 7,
  parameter int ZERO_INT = 0,
  parameter int ZERO_FP  = NF,
  parameter int ZERO_CC  = NC,
  parameter int AW       = $clog2(NI + NF + NC + NM),
  parameter int PW       = $clog2(PI + PF + PC + NM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_arch,
  output logic              rsp_valid,
  output logic [PW-1:0]     rsp_new,
  output logic [PW-1:0]     rsp_old,
  input  logic [NLK*AW-1:0] lk_arch,
  output logic [NLK*PW-1:0] lk_phys,
  input  logic              we_valid,
  input  logic [AW-1:0]     we_arch,
  input  logic [PW-1:0]     we_phys,
  input  logic [PW-1:0]     fl_int_head,
  input  logic [CW-1:0]     fl_int_count,
  output logic              fl_int_pop,
  input  logic [PW-1:0]     fl_fp_head,
  input  logic [CW-1:0]     fl_fp_count,
  output logic              fl_fp_pop,
  input  logic [PW-1:0]     fl_cc_head,
  input  logic [CW-1:0]     fl_cc_count,
  output logic              fl_cc_pop,
  input  logic [CW-1:0]     need_int,
  input  logic [CW-1:0]     need_fp,
  input  logic [CW-1:0]     need_cc,
  output logic [CW-1:0]     free_min,
  output logic              can_rename
);
  localparam int TOTAL = PI + PF + PC;
  localparam int NRD   = NLK + 1;
  localparam int REN_P = NLK;

  // shared read index vector: lookup ports first, rename old-value port last
  logic [NRD*AW-1:0] rd_idx;
  logic [NRD*PW-1:0] rd_int, rd_fp, rd_cc;

  reg_cls_e      ren_cls, we_cls;
  logic [AW-1:0] ren_rel, we_rel;
  logic          ren_zero, ren_alloc, accept;
  logic [PW-1:0] ren_cur, ren_misc;

  rmap_decode #(.AW(AW), .NI(NI), .NF(NF), .NC(NC)) u_dec_ren (
    .uidx(req_arch), .cls(ren_cls), .rel(ren_rel));
  rmap_decode #(.AW(AW), .NI(NI), .NF(NF), .NC(NC)) u_dec_we (
    .uidx(we_arch), .cls(we_cls), .rel(we_rel));

  assign rd_idx[REN_P*AW +: AW] = ren_rel;

  for (genvar g = 0; g < NLK; g++) begin : g_lk
    reg_cls_e      cls;
    logic [AW-1:0] rel;
    logic [PW-1:0] val;
    rmap_decode #(.AW(AW), .NI(NI), .NF(NF), .NC(NC)) u_dec (
      .uidx(lk_arch[g*AW +: AW]), .cls(cls), .rel(rel));
    assign rd_idx[g*AW +: AW] = rel;
    always_comb begin
      case (cls)
        CLS_INT: val = rd_int[g*PW +: PW];
        CLS_FP:  val = rd_fp[g*PW +: PW];
        CLS_CC:  val = rd_cc[g*PW +: PW];
        default: val = PW'(TOTAL) + PW'(rel);
      endcase
    end
    assign lk_phys[g*PW +: PW] = val;
  end

  // zero-register detection per class
  always_comb begin
    case (ren_cls)
      CLS_INT: ren_zero = (ren_rel == AW'(ZERO_INT));
      CLS_FP:  ren_zero = (ren_rel == AW'(ZERO_FP));
      CLS_CC:  ren_zero = (ren_rel == AW'(ZERO_CC));
      default: ren_zero = 1'b0;
    endcase
  end

  always_comb begin
    case (ren_cls)
      CLS_INT: req_ready = ren_zero || (fl_int_count != '0);
      CLS_FP:  req_ready = ren_zero || (fl_fp_count  != '0);
      CLS_CC:  req_ready = ren_zero || (fl_cc_count  != '0);
      default: req_ready = 1'b1;
    endcase
  end

  assign accept    = req_valid && req_ready;
  assign ren_alloc = accept && !ren_zero && (ren_cls != CLS_MISC);
  assign ren_misc  = PW'(TOTAL) + PW'(ren_rel);

  assign fl_int_pop = ren_alloc && (ren_cls == CLS_INT);
  assign fl_fp_pop  = ren_alloc && (ren_cls == CLS_FP);
  assign fl_cc_pop  = ren_alloc && (ren_cls == CLS_CC);

  always_comb begin
    case (ren_cls)
      CLS_INT: ren_cur = rd_int[REN_P*PW +: PW];
      CLS_FP:  ren_cur = rd_fp[REN_P*PW +: PW];
      CLS_CC:  ren_cur = rd_cc[REN_P*PW +: PW];
      default: ren_cur = ren_misc;
    endcase
  end

  always_comb begin
    rsp_old = ren_cur;
    case (ren_cls)
      CLS_INT: rsp_new = ren_zero ? ren_cur : fl_int_head;
      CLS_FP:  rsp_new = ren_zero ? ren_cur : fl_fp_head;
      CLS_CC:  rsp_new = ren_zero ? ren_cur : fl_cc_head;
      default: rsp_new = ren_misc;
    endcase
  end
  assign rsp_valid = accept;

  rmap_class_table #(.NARCH(NI), .PBASE(0), .AW(AW), .PW(PW), .NRD(NRD)) u_tab_int (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_phys(rd_int),
    .ren_en(fl_int_pop), .ren_idx(ren_rel), .ren_phys(fl_int_head),
    .wr_en(we_valid && (we_cls == CLS_INT)), .wr_idx(we_rel), .wr_phys(we_phys));

  rmap_class_table #(.NARCH(NF), .PBASE(PI), .AW(AW), .PW(PW), .NRD(NRD)) u_tab_fp (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_phys(rd_fp),
    .ren_en(fl_fp_pop), .ren_idx(ren_rel), .ren_phys(fl_fp_head),
    .wr_en(we_valid && (we_cls == CLS_FP)), .wr_idx(we_rel), .wr_phys(we_phys));

  rmap_class_table #(.NARCH(NC), .PBASE(PI + PF), .AW(AW), .PW(PW), .NRD(NRD)) u_tab_cc (
    .clk(clk), .rst_n(rst_n), .rd_idx(rd_idx), .rd_phys(rd_cc),
    .ren_en(fl_cc_pop), .ren_idx(ren_rel), .ren_phys(fl_cc_head),
    .wr_en(we_valid && (we_cls == CLS_CC)), .wr_idx(we_rel), .wr_phys(we_phys));

  rmap_status #(.CW(CW)) u_status (
    .cnt_int(fl_int_count), .cnt_fp(fl_fp_count), .cnt_cc(fl_cc_count),
    .need_int(need_int), .need_fp(need_fp), .need_cc(need_cc),
    .free_min(free_min), .can_rename(can_rename));
endmodule

// File: rtl/reg_rename_map_chk.sv
`timescale 1ns/1ps
module reg_rename_map_chk #(
  parameter int NI       = 16,
  parameter int NF       = 16,
  parameter int NC       = 4,
  parameter int NM       = 8,
  parameter int TOTAL    = 72,
  parameter int NLK      = 2,
  parameter int CW       = 7,
  parameter int ZERO_INT = 0,
  parameter int AW       = 6,
  parameter int PW       = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     req_arch,
  input logic              rsp_valid,
  input logic [PW-1:0]     rsp_new,
  input logic [PW-1:0]     rsp_old,
  input logic [NLK*AW-1:0] lk_arch,
  input logic [NLK*PW-1:0] lk_phys,
  input logic              we_valid,
  input logic [AW-1:0]     we_arch,
  input logic [PW-1:0]     we_phys,
  input logic [PW-1:0]     fl_int_head,
  input logic [CW-1:0]     fl_int_count,
  input logic              fl_int_pop,
  input logic [CW-1:0]     fl_fp_count,
  input logic              fl_fp_pop,
  input logic [CW-1:0]     fl_cc_count,
  input logic              fl_cc_pop
);
  localparam int MB = NI + NF + NC;

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fl_int_pop, fl_fp_pop, fl_cc_pop})); // R2

  AST_INT_POP_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fl_int_pop |-> (rsp_valid && rsp_new == fl_int_head)); // R2

  AST_NO_POP_INT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_int_pop |-> (fl_int_count != '0)); // R6
  AST_NO_POP_FP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_fp_pop |-> (fl_fp_count != '0)); // R6
  AST_NO_POP_CC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fl_cc_pop |-> (fl_cc_count != '0)); // R6

  AST_MISC_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && int'(req_arch) >= MB) |->
      (rsp_new == rsp_old && int'(rsp_new) == TOTAL + int'(req_arch) - MB)); // R5

  AST_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ZERO_INT < NI && int'(req_arch) == ZERO_INT) |->
      (rsp_new == rsp_old && !fl_int_pop)); // R4

  for (genvar g = 0; g < NLK; g++) begin : g_lkchk
    AST_WRITE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (we_valid && int'(we_arch) < MB) ##1 (lk_arch[g*AW +: AW] == $past(we_arch)) |->
        (lk_phys[g*PW +: PW] == $past(we_phys))); // R7

    AST_RENAME_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_int_pop && !we_valid) ##1 (lk_arch[g*AW +: AW] == $past(req_arch)) |->
        (lk_phys[g*PW +: PW] == $past(rsp_new))); // R2
  end
endmodule

bind reg_rename_map reg_rename_map_chk #(
  .NI(NI), .NF(NF), .NC(NC), .NM(NM), .TOTAL(PI + PF + PC), .NLK(NLK),
  .CW(CW), .ZERO_INT(ZERO_INT), .AW(AW), .PW(PW)
) u_chk (.*);

// File: tb/test_reg_rename_map.sv
`timescale 1ns/1ps
module test_reg_rename_map;
  localparam int AW = 6, PW = 7, CW = 7, NLK = 2;
  localparam int MB = 36, TOT = 72;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              req_valid = 1'b0, req_ready;
  logic [AW-1:0]     req_arch = '0;
  logic              rsp_valid;
  logic [PW-1:0]     rsp_new, rsp_old;
  logic [NLK*AW-1:0] lk_arch = '0;
  logic [NLK*PW-1:0] lk_phys;
  logic              we_valid = 1'b0;
  logic [AW-1:0]     we_arch = '0;
  logic [PW-1:0]     we_phys = '0;
  logic [PW-1:0]     fl_int_head, fl_fp_head, fl_cc_head;
  logic [CW-1:0]     fl_int_count, fl_fp_count, fl_cc_count;
  logic              fl_int_pop, fl_fp_pop, fl_cc_pop;
  logic [CW-1:0]     need_int = '0, need_fp = '0, need_cc = '0;
  logic [CW-1:0]     free_min;
  logic              can_rename;

  reg_rename_map i_reg_rename_map (.*);

  int tests = 0, fails = 0;
  int m_int [16];
  int m_fp  [16];
  int m_cc  [4];
  int q_int [$];
  int q_fp  [$];
  int q_cc  [$];

  typedef struct { int nw; int od; int pop; string tag; } exp_t;
  exp_t exp_q [$];

  task automatic check(string req, int act, int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int map_get(int ua);
    if (ua < 16) return m_int[ua];
    if (ua < 32) return m_fp[ua-16];
    if (ua < MB) return m_cc[ua-32];
    return ua - MB + TOT;
  endfunction

  function automatic void map_set(int ua, int v);
    if (ua < 16)      m_int[ua] = v;
    else if (ua < 32) m_fp[ua-16] = v;
    else if (ua < MB) m_cc[ua-32] = v;
  endfunction

  task automatic refresh_fl();
    fl_int_count = CW'(q_int.size());
    fl_fp_count  = CW'(q_fp.size());
    fl_cc_count  = CW'(q_cc.size());
    fl_int_head  = q_int.size() > 0 ? PW'(q_int[0]) : '0;
    fl_fp_head   = q_fp.size()  > 0 ? PW'(q_fp[0])  : '0;
    fl_cc_head   = q_cc.size()  > 0 ? PW'(q_cc[0])  : '0;
  endtask

  // monitor: compares each response against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rsp_valid) begin
        int pc;
        pc = fl_int_pop ? 1 : fl_fp_pop ? 2 : fl_cc_pop ? 3 : 0;
        if (exp_q.size() == 0) begin
          check("R6 unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " new"}, int'(rsp_new), e.nw);
          check({e.tag, " old"}, int'(rsp_old), e.od);
          check({e.tag, " pop"}, pc, e.pop);
        end
      end
    end
  end

  // driver: one rename, optional same-cycle write-entry
  task automatic rename_op(int ua, bit wv, int wa, int wp, string tag);
    exp_t e;
    bit ok;
    int cls, cur;
    @(negedge clk);
    req_valid = 1'b1; req_arch = AW'(ua);
    we_valid = wv; we_arch = AW'(wa); we_phys = PW'(wp);
    ok = 1'b1; e.tag = tag; e.pop = 0;
    cls = ua < 16 ? 1 : ua < 32 ? 2 : ua < MB ? 3 : 0;
    cur = map_get(ua);
    if (cls == 0 || (cls == 1 && ua == 0)) begin
      e.nw = cur; e.od = cur;
    end else if ((cls == 1 && q_int.size() == 0) || (cls == 2 && q_fp.size() == 0) ||
                 (cls == 3 && q_cc.size() == 0)) begin
      ok = 1'b0;
    end else begin
      e.nw = cls == 1 ? q_int[0] : cls == 2 ? q_fp[0] : q_cc[0];
      e.od = cur; e.pop = cls;
    end
    if (ok) exp_q.push_back(e);
    #2;
    // R3: lookup port 0 in the rename cycle shows the pre-rename mapping
    check("R3 same-cycle lookup", int'(lk_phys[PW-1:0]), map_get(int'(lk_arch[AW-1:0])));
    if (!ok) check({tag, " ready"}, int'(req_ready), 0);
    @(posedge clk);
    #1;
    if (ok && e.pop != 0) begin
      map_set(ua, e.nw);
      if (e.pop == 1) void'(q_int.pop_front());
      if (e.pop == 2) void'(q_fp.pop_front());
      if (e.pop == 3) void'(q_cc.pop_front());
    end
    if (wv) map_set(wa, wp);
    req_valid = 1'b0; we_valid = 1'b0;
    refresh_fl();
  endtask

  task automatic write_op(int wa, int wp);
    @(negedge clk);
    we_valid = 1'b1; we_arch = AW'(wa); we_phys = PW'(wp);
    @(posedge clk);
    #1;
    map_set(wa, wp);
    we_valid = 1'b0;
  endtask

  task automatic look(int port, int ua, string req);
    @(negedge clk);
    lk_arch[port*AW +: AW] = AW'(ua);
    #1;
    check(req, int'(lk_phys[port*PW +: PW]), map_get(ua));
  endtask

  task automatic status_chk(int ni, int nf, int nc, string req);
    int expv;
    @(negedge clk);
    need_int = CW'(ni); need_fp = CW'(nf); need_cc = CW'(nc);
    #1;
    expv = (ni <= q_int.size() && nf <= q_fp.size() && nc <= q_cc.size()) ? 1 : 0;
    check(req, int'(can_rename), expv);
    expv = q_int.size() < q_fp.size() ? q_int.size() : q_fp.size();
    check("R10 free_min", int'(free_min), expv);
  endtask

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_int[i] = i;
    for (int i = 0; i < 16; i++) m_fp[i] = 32 + i;
    for (int i = 0; i < 4; i++)  m_cc[i] = 64 + i;
    for (int i = 16; i < 32; i++) q_int.push_back(i);
    for (int i = 48; i < 60; i++) q_fp.push_back(i);
    for (int i = 68; i < 72; i++) q_cc.push_back(i);
    refresh_fl();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset mapping and range decode
    look(0, 5, "R1 int reset");
    look(1, 19, "R1 fp reset");
    look(0, 33, "R1 cc reset");
    look(1, 31, "R1 fp top reset");
    check("R2 no response at idle", int'(rsp_valid), 0);
    look(1, 40, "R5 misc lookup");
    status_chk(16, 12, 4, "R9 all equal");
    status_chk(0, 0, 5, "R9 cc short");
    status_chk(0, 13, 0, "R9 fp short");

    // R2: plain integer renames
    look(0, 3, "R2 pre");
    rename_op(3, 0, 0, 0, "R2 int rename");
    look(1, 3, "R2 new mapping");
    rename_op(3, 0, 0, 0, "R2 int rename again");
    look(1, 3, "R2 second mapping");

    // R3: rename and lookup of the same fp register
    look(0, 18, "R3 pre");
    rename_op(18, 0, 0, 0, "R3 fp rename");
    look(0, 18, "R3 next cycle");
    rename_op(31, 0, 0, 0, "R1 fp last entry rename");
    look(1, 31, "R1 fp last entry");

    // R4: zero register
    rename_op(0, 0, 0, 0, "R4 zero rename");
    look(0, 0, "R4 zero unchanged");

    // R5: misc
    rename_op(40, 0, 0, 0, "R5 misc rename");
    look(1, 40, "R5 misc after");

    // R6: drain cc and stall
    rename_op(32, 0, 0, 0, "R6 cc0");
    rename_op(33, 0, 0, 0, "R6 cc1");
    rename_op(34, 0, 0, 0, "R6 cc2");
    rename_op(35, 0, 0, 0, "R6 cc3");
    rename_op(32, 0, 0, 0, "R6 cc stall");
    look(0, 32, "R6 map unchanged");
    status_chk(0, 0, 1, "R9 cc empty");
    status_chk(2, 2, 0, "R9 cc zero demand");

    // R7: write-entry
    write_op(5, 30);
    look(0, 5, "R7 write int");
    write_op(33, 12);
    look(1, 33, "R7 write cc");
    write_op(41, 3);
    look(1, 41, "R7 misc write ignored");

    // R8: rename and write-entry collide
    rename_op(7, 1, 7, 25, "R8 collide rename");
    look(0, 7, "R8 write wins");
    rename_op(8, 1, 9, 26, "R8 distinct rename");
    look(0, 8, "R8 rename kept");
    look(1, 9, "R8 write kept");
    status_chk(1, 1, 0, "R9 after traffic");

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule